// File: doc/BRIEF.md
# LIN Header Identifier Acceptance Filter

This block decides, for every received LIN header, whether the frame concerns this node. A bank of sixteen filter entries is compared in parallel against the 6-bit frame identifier. A frame that matches no enabled entry is dropped silently. A frame that matches produces a result naming the winning entry, whether the node must receive or send the response, and the expected data length. Software is therefore involved only for wanted frames.

Entries are grouped in pairs. A pair in list mode acts as two independent exact-match entries. A pair in mask mode acts as one entry. In that case the even register gives the reference identifier and the odd register's identifier field gives a per-bit care mask, so one pair can accept a whole family of identifiers. The header side presents the protected identifier with a one-cycle strobe. There is no back-pressure: a strobe is accepted in every cycle, including back-to-back cycles. Each strobe yields exactly one registered result one cycle later. The result pins are plain status and carry no handshake.

Top module: `lin_id_filter_bank`

## Requirements
- R1: After reset every output is low, every entry is disabled, and every pair is in list mode.
- R2: Each cycle with `id_valid` high gives `res_valid` high in the following cycle only. Strobes in consecutive cycles each give a result, and `res_valid` is low after a cycle without a strobe.
- R3: In list mode an enabled entry matches when all six identifier bits equal its stored identifier.
- R4: In mask mode pair p is one entry at index 2p. A bit of the odd register's identifier field at 1 forces that identifier bit to match the even register, and a 0 makes it don't-care. Enable, direction and length come from the even register, and the odd register's own enable, direction and length have no effect.
- R5: Bits [7:6] of `id_pid` (the parity bits) take no part in the compare. Bits [5:0] are the identifier.
- R6: A disabled entry never matches. With no match the result shows `res_hit`=0 and `res_idx`, `res_dir`, `res_len` all zero.
- R7: When several entries match, the lowest index wins.
- R8: On a hit, `res_dir` (1 = node transmits the response, 0 = node receives it) and `res_len` carry the winning entry's stored values.
- R9: `cfg_wdata` is {enable[11], dir[10], len[9:6], id[5:0]} written to entry `cfg_addr` when `cfg_we` is high. A strobe in the same cycle as a write sees the old contents, and a strobe in the next cycle sees the new ones.
- R10: `mode_we` loads `mode_wdata`, where bit p = 1 puts pair p (entries 2p, 2p+1) into mask mode. The mode takes effect for strobes from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_addr | input | 4 | Entry index to write |
| cfg_wdata | input | 12 | Entry contents {enable, dir, len, id} |
| mode_we | input | 1 | Pair mode write enable |
| mode_wdata | input | 8 | Per-pair mode, 1 = mask mode |
| id_valid | input | 1 | Header identifier strobe |
| id_pid | input | 8 | Protected identifier, parity in [7:6] |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Frame accepted |
| res_idx | output | 4 | Winning entry index |
| res_dir | output | 1 | Response direction of winner |
| res_len | output | 4 | Data length of winner |

## Verification
The bench builds the block with its default of sixteen entries, which makes eight pairs. This lets a single run mix list pairs, mask pairs, a disabled mask pair with an all-don't-care mask, and a duplicate identifier in a higher entry for the priority check. The top entry 15 is used as well. A back-to-back stream of identifiers with varied parity bits covers the parallel compare. Directed cases cover a write colliding with a strobe, mode changes in both directions, and a reset during operation.

// File: rtl/lin_filt_pkg.sv
package lin_filt_pkg;
  localparam int unsigned LIN_ID_W  = 6;
  localparam int unsigned LIN_PID_W = 8;
  localparam int unsigned LIN_LEN_W = 4;

  typedef struct packed {
    logic                 en;
    logic                 dir;
    logic [LIN_LEN_W-1:0] len;
    logic [LIN_ID_W-1:0]  id;
  } filt_entry_t;

  localparam int unsigned ENTRY_W = $bits(filt_entry_t);
endpackage

// File: rtl/lin_filt_regs.sv
module lin_filt_regs
  import lin_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT),
  localparam int unsigned NPAIR   = NUM_FILT / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_addr,
  input  logic [ENTRY_W-1:0]        cfg_wdata,
  input  logic                      mode_we,
  input  logic [NPAIR-1:0]          mode_wdata,
  output filt_entry_t [NUM_FILT-1:0] entries,
  output logic [NPAIR-1:0]          mask_mode
);
  filt_entry_t [NUM_FILT-1:0] entries_q;
  logic [NPAIR-1:0]           mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entries_q <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_FILT; i++) begin
        if (cfg_addr == i[IDX_W-1:0]) entries_q[i] <= filt_entry_t'(cfg_wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  assign entries   = entries_q;
  assign mask_mode = mode_q;

  // Mode only moves on a mode write.
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q));

  // Entries only move on an entry write.
  p_entry_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(entries_q));
endmodule

// File: rtl/lin_filt_pair.sv
module lin_filt_pair
  import lin_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LIN_ID_W-1:0] rx_id,
  input  logic                mask_mode,
  input  logic                even_en,
  input  logic [LIN_ID_W-1:0] even_id,
  input  logic                odd_en,
  input  logic [LIN_ID_W-1:0] odd_id,
  output logic [1:0]          hit
);
  logic [LIN_ID_W-1:0] care;
  logic [LIN_ID_W-1:0] diff;

  // In mask mode the odd identifier field becomes the care mask.
  assign care = mask_mode ? odd_id : {LIN_ID_W{1'b1}};
  assign diff = (rx_id ^ even_id) & care;

  assign hit[0] = even_en && (diff == '0);
  assign hit[1] = !mask_mode && odd_en && (rx_id == odd_id);

  // A full care mask behaves like an exact compare on the even entry.
  p_full_mask_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_mode && (odd_id == {LIN_ID_W{1'b1}})) |-> (hit[0] == (even_en && (rx_id == even_id))));

  // The odd slot is silent while the pair is a mask entry.
  p_odd_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_mode |-> !hit[1]);
endmodule

// File: rtl/lin_filt_pick.sv
module lin_filt_pick
  import lin_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT),
  localparam int unsigned NPAIR   = NUM_FILT / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_FILT-1:0]        hit_vec,
  input  filt_entry_t [NUM_FILT-1:0] entries,
  input  logic [NPAIR-1:0]           mask_mode,
  output logic                       any_hit,
  output logic [IDX_W-1:0]           win_idx,
  output logic                       win_dir,
  output logic [LIN_LEN_W-1:0]       win_len
);
  // Scan from the top so the lowest matching index is written last.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    win_dir = 1'b0;
    win_len = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = i[IDX_W-1:0];
        win_dir = entries[i].dir;
        win_len = entries[i].len;
      end
    end
  end

  p_winner_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[win_idx]);

  p_no_lower_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & ((NUM_FILT'(1) << win_idx) - NUM_FILT'(1))) == '0));

  p_mask_idx_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && mask_mode[win_idx >> 1]) |-> !win_idx[0]);
endmodule

// File: rtl/lin_id_filter_bank.sv
module lin_id_filter_bank
  import lin_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT),
  localparam int unsigned NPAIR   = NUM_FILT / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_addr,
  input  logic [ENTRY_W-1:0]   cfg_wdata,
  input  logic                 mode_we,
  input  logic [NPAIR-1:0]     mode_wdata,
  input  logic                 id_valid,
  input  logic [LIN_PID_W-1:0] id_pid,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [IDX_W-1:0]     res_idx,
  output logic                 res_dir,
  output logic [LIN_LEN_W-1:0] res_len
);
  filt_entry_t [NUM_FILT-1:0] entries;
  logic [NPAIR-1:0]           mask_mode;
  logic [NUM_FILT-1:0]        hit_vec;
  logic [LIN_ID_W-1:0]        rx_id;
  logic                       any_hit;
  logic [IDX_W-1:0]           win_idx;
  logic                       win_dir;
  logic [LIN_LEN_W-1:0]       win_len;

  // Parity bits are dropped before the compare.
  assign rx_id = id_pid[LIN_ID_W-1:0];

  lin_filt_regs #(.NUM_FILT(NUM_FILT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .entries    (entries),
    .mask_mode  (mask_mode)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    lin_filt_pair u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_id     (rx_id),
      .mask_mode (mask_mode[p]),
      .even_en   (entries[2*p].en),
      .even_id   (entries[2*p].id),
      .odd_en    (entries[2*p+1].en),
      .odd_id    (entries[2*p+1].id),
      .hit       (hit_vec[2*p+1:2*p])
    );
  end

  lin_filt_pick #(.NUM_FILT(NUM_FILT)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vec   (hit_vec),
    .entries   (entries),
    .mask_mode (mask_mode),
    .any_hit   (any_hit),
    .win_idx   (win_idx),
    .win_dir   (win_dir),
    .win_len   (win_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_dir   <= 1'b0;
      res_len   <= '0;
    end else begin
      res_valid <= id_valid;
      res_hit   <= id_valid && any_hit;
      res_idx   <= (id_valid && any_hit) ? win_idx : '0;
      res_dir   <= id_valid && any_hit && win_dir;
      res_len   <= (id_valid && any_hit) ? win_len : '0;
    end
  end

  p_strobe_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid);

  p_hit_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);

  p_miss_zero_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && !res_dir && res_len == '0));
endmodule

// File: tb/sim_lin_id_filter_bank.sv
module sim_lin_id_filter_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        mode_we;
  logic [7:0]  mode_wdata;
  logic        id_valid;
  logic [7:0]  id_pid;
  logic        res_valid, res_hit, res_dir;
  logic [3:0]  res_idx, res_len;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lin_id_filter_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .id_valid(id_valid), .id_pid(id_pid), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_dir(res_dir), .res_len(res_len)
  );

  // {pid, hit, idx, dir, len}
  localparam int NVEC = 12;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h10, 1'b1, 4'd0,  1'b0, 4'd2},   // R3 R7: entry 6 also holds 0x10
    {8'h90, 1'b1, 4'd0,  1'b0, 4'd2},   // R5
    {8'h21, 1'b1, 4'd1,  1'b1, 4'd8},   // R3 R8
    {8'h30, 1'b1, 4'd2,  1'b1, 4'd4},   // R4
    {8'h73, 1'b1, 4'd2,  1'b1, 4'd4},   // R4 R5
    {8'h34, 1'b0, 4'd0,  1'b0, 4'd0},   // R4 cared bit differs
    {8'h05, 1'b1, 4'd5,  1'b0, 4'd1},   // R6 entry 4 disabled
    {8'h3F, 1'b1, 4'd15, 1'b1, 4'd15},  // R8 top entry
    {8'h00, 1'b0, 4'd0,  1'b0, 4'd0},   // R6 disabled catch-all
    {8'hFF, 1'b1, 4'd15, 1'b1, 4'd15},  // R5
    {8'h22, 1'b0, 4'd0,  1'b0, 4'd0},   // R6
    {8'hD1, 1'b0, 4'd0,  1'b0, 4'd0}    // R5 R6
  };

  function automatic logic [10:0] res_now();
    return {res_valid, res_hit, res_idx, res_dir, res_len};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_entry(input int a, input logic en, input logic dir,
                          input logic [3:0] len, input logic [5:0] id);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = {en, dir, len, id};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] m);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic probe(input logic [7:0] pid, output logic [10:0] r);
    @(negedge clk);
    id_valid = 1'b1; id_pid = pid;
    @(negedge clk);
    id_valid = 1'b0;
    r = res_now();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [10:0] r;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    mode_we = 1'b0; mode_wdata = '0; id_valid = 1'b0; id_pid = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'(res_now()), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", 32'(res_now()), 32'h0);

    probe(8'h00, r);
    chk("R1 no entry enabled", 32'(r), 32'h400);
    @(negedge clk);
    chk("R2 valid drops without strobe", 32'(res_valid), 32'h0);

    wr_entry(2, 1'b1, 1'b1, 4'd4, 6'h30);
    wr_entry(3, 1'b0, 1'b0, 4'd0, 6'h3C);
    probe(8'h31, r);
    chk("R1 default list mode miss", 32'(r), 32'h400);
    probe(8'h30, r);
    chk("R3 list exact hit", 32'(r), 32'(11'b1_1_0010_1_0100));

    wr_mode(8'b0001_0010);
    probe(8'h31, r);
    chk("R10 mask mode hit", 32'(r), 32'(11'b1_1_0010_1_0100));
    wr_entry(3, 1'b1, 1'b0, 4'd9, 6'h3C);
    probe(8'h32, r);
    chk("R4 odd fields ignored", 32'(r), 32'(11'b1_1_0010_1_0100));

    wr_entry(0,  1'b1, 1'b0, 4'd2,  6'h10);
    wr_entry(1,  1'b1, 1'b1, 4'd8,  6'h21);
    wr_entry(4,  1'b0, 1'b1, 4'd6,  6'h05);
    wr_entry(5,  1'b1, 1'b0, 4'd1,  6'h05);
    wr_entry(6,  1'b1, 1'b1, 4'd3,  6'h10);
    wr_entry(8,  1'b0, 1'b1, 4'd7,  6'h00);
    wr_entry(9,  1'b1, 1'b0, 4'd0,  6'h00);
    wr_entry(15, 1'b1, 1'b1, 4'd15, 6'h3F);

    // Back-to-back stream of table vectors.
    @(negedge clk);
    id_valid = 1'b1; id_pid = VEC[0][17:10];
    for (int i = 1; i <= NVEC; i++) begin
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 R6 R7 R8 vector %0d", i - 1),
          32'(res_now()), 32'({1'b1, VEC[i-1][9:0]}));
      if (i < NVEC) id_pid = VEC[i][17:10];
      else          id_valid = 1'b0;
    end
    @(negedge clk);
    chk("R2 quiet after stream", 32'(res_valid), 32'h0);

    // Write colliding with a strobe sees the old entry.
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 12'h021;
    id_valid = 1'b1; id_pid = 8'h21;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 same-cycle write old contents", 32'(res_now()), 32'(11'b1_1_0001_1_1000));
    @(negedge clk);
    id_valid = 1'b0;
    chk("R9 next strobe new contents", 32'(res_now()), 32'h400);

    wr_mode(8'h00);
    probe(8'h31, r);
    chk("R10 back to list mode miss", 32'(r), 32'h400);
    probe(8'h3C, r);
    chk("R10 odd entry live in list mode", 32'(r), 32'(11'b1_1_0011_0_1001));

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset outputs", 32'(res_now()), 32'h0);
    rst_n = 1'b1;
    probe(8'h10, r);
    chk("R1 entries cleared by reset", 32'(r), 32'h400);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule